// File: doc/BRIEF.md
# Big-Endian Register Width Adapter

This block sits between a processor-side bus and a peripheral register space whose registers have mixed native widths. A requester may issue byte, halfword or word accesses at any offset. The adapter looks up the native width of the 4-byte slot the offset falls in, then turns the request into one or more downstream accesses of exactly that width. All byte ordering is big-endian: the lowest offset is the most significant byte.

There are three cases. A request wider than the register is split into several native accesses at rising offsets, and the first access fills the most significant part. A read narrower than the register reads the whole aligned register once and selects the addressed bytes. A write narrower than the register becomes a read of the aligned register followed by a write of the merged value.

The downstream side answers reads in the same cycle and carries one native access per cycle. An access to an unused slot, to an offset beyond the limit, or with an illegal size ends with an error pulse. Such an access produces no downstream traffic.

Top module: `regwidth_adapter`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `busy`, `done`, `err` and `dnValid` are all low.
- R2: The native width of an offset comes from the 2-bit slot code at position `reqAddr[9:2]` of the slot map: 1 = byte, 2 = halfword, 3 = word, 0 = unused. The default map repeats every 256 bytes: offsets 0x00–0x3F are byte, 0x40–0x7F are halfword, 0x80–0xBF are word, and 0xC0–0xFF are unused. Every downstream access carries `dnSize` equal to the native width (0 = byte, 1 = halfword, 2 = word), and its address is aligned to that width.
- R3: A read wider than the native width issues (request bytes / native bytes) reads at rising offsets. The first result lands in the most significant bits of `rdata`.
- R4: A read narrower than the native width issues one read of the aligned register. It returns the addressed bytes, where a lower offset selects more significant bits, right-justified in `rdata`.
- R5: A write wider than the native width issues (request bytes / native bytes) writes at rising offsets. The first write carries the most significant part of `reqWdata`.
- R6: A write narrower than the native width issues exactly two accesses: a read of the aligned register, then a write of it. The write changes only the addressed bytes.
- R7: A request whose size equals the native width issues exactly one downstream access.
- R8: A request is refused with a one-cycle `err` pulse in the cycle after acceptance, with no downstream access and no `done`, in any of these cases: its slot code is 0, its offset is above `LIMIT` (default 0x200), or `reqSize` is 3.
- R9: A request is accepted only while `busy` is low. `busy` is high from the cycle after acceptance through the last downstream access. `done` then pulses for one cycle with read data right-justified in `rdata`. A new request may be accepted in the `done` cycle.
- R10: Offset bits below the request size are ignored: a halfword request behaves as at an even offset, and a word request as at a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| reqAddr | input | ADDR_W | Register offset |
| reqWdata | input | 32 | Write data, right-justified |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |
| rdata | output | 32 | Read result, right-justified, valid with done |
| dnValid | output | 1 | Downstream access this cycle |
| dnWrite | output | 1 | Downstream access is a write |
| dnSize | output | 2 | Native width of the downstream access |
| dnAddr | output | ADDR_W | Native-aligned downstream offset |
| dnWdata | output | 32 | Downstream write data, right-justified |
| dnRdata | input | 32 | Downstream read data, same cycle, right-justified |

## Verification
The completion pulse of one request and the acceptance of the next can share a cycle. The bench provokes this by presenting each new request on the very falling edge where it sees `done` or `err`. The scoreboard then judges that the earlier result is intact, and that the next request's downstream access count, widths and data match an independent byte-array model. The read-modify-write cases are placed back to back with read-backs, so a merge that clobbers a neighbouring byte shows up in the following read.

// File: rtl/rwa_pkg.sv
package rwa_pkg;
  localparam int MAX_SLOTS = 256;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_B    = 2'd1,
    SLOT_H    = 2'd2,
    SLOT_W    = 2'd3
  } slotCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       issue;
    logic       rmwRd;
    logic       rmwWr;
    logic [1:0] piece;
  } rwaCtl_t;

  function automatic logic [DATA_W-1:0] laneMask(input logic [1:0] lg);
    case (lg)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // default layout, repeating every 256 bytes: byte, half, word, unused
  function automatic logic [2*MAX_SLOTS-1:0] defaultMap();
    logic [2*MAX_SLOTS-1:0] m;
    logic [7:0] s;
    m = '0;
    for (int i = 0; i < MAX_SLOTS; i++) begin
      s = 8'(i);
      case (s[5:4])
        2'd0:    m[2*i +: 2] = SLOT_B;
        2'd1:    m[2*i +: 2] = SLOT_H;
        2'd2:    m[2*i +: 2] = SLOT_W;
        default: m[2*i +: 2] = SLOT_NONE;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/rwa_ctrl.sv
module rwa_ctrl
  import rwa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqBad,
  input  logic       isRmw,
  input  logic [1:0] pieceLast,
  output rwaCtl_t    ctl,
  output logic       busy,
  output logic       done,
  output logic       err
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WBACK} state_e;

  state_e     state;
  logic [1:0] cnt;

  always_comb begin
    ctl       = '0;
    ctl.load  = (state == ST_IDLE) && reqValid && !reqBad;
    ctl.issue = (state != ST_IDLE);
    ctl.rmwRd = (state == ST_RUN) && isRmw;
    ctl.rmwWr = (state == ST_WBACK);
    ctl.piece = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (reqBad) begin
              err <= 1'b1;
            end else begin
              state <= ST_RUN;
              cnt   <= '0;
            end
          end
        end
        ST_RUN: begin
          if (isRmw) begin
            state <= ST_WBACK;
          end else if (cnt == pieceLast) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 2'd1;
          end
        end
        default: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/rwa_datapath.sv
module rwa_datapath
  import rwa_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LIMIT = 'h200,
  parameter logic [2*MAX_SLOTS-1:0] SLOT_MAP = defaultMap()
) (
  input  logic              clk,
  input  logic              rst,
  input  rwaCtl_t           ctl,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              reqBad,
  output logic              isRmw,
  output logic [1:0]        pieceLast,
  output logic              dnWrite,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [1:0]        dnSize,
  output logic [31:0]       dnWdata,
  input  logic [31:0]       dnRdata,
  output logic [31:0]       rdata
);
  localparam logic [ADDR_W:0] LIMIT_V = (ADDR_W+1)'(LIMIT);

  // request-side decode
  logic [7:0]        slotIdx;
  logic [1:0]        slotCode;
  logic [1:0]        lgNreq;
  logic [ADDR_W-1:0] reqAlign;

  assign slotIdx  = 8'(reqAddr[ADDR_W-1:2]);
  assign slotCode = SLOT_MAP[{slotIdx, 1'b0} +: 2];
  assign lgNreq   = slotCode - 2'd1;
  assign reqBad   = (slotCode == SLOT_NONE) || ({1'b0, reqAddr} > LIMIT_V) || (reqSize == 2'd3);

  always_comb begin
    case (reqSize)
      2'd0:    reqAlign = reqAddr;
      2'd1:    reqAlign = {reqAddr[ADDR_W-1:1], 1'b0};
      default: reqAlign = {reqAddr[ADDR_W-1:2], 2'b00};
    endcase
  end

  // latched request
  logic [ADDR_W-1:0] baseQ;
  logic [1:0]        lgAQ, lgNQ, pieceLastQ;
  logic              wrQ, isRmwQ;
  logic [31:0]       wdQ, accQ;

  // issue-side arithmetic
  logic              wide;
  logic [ADDR_W-1:0] nativeAlign;
  logic [2:0]        pieceByteOff, pieceBytes, nBytes, aBytes, offIn, laneBytes;
  logic [5:0]        pieceSh, laneSh, nBits;
  logic [31:0]       pieceData, laneA, laneN;

  assign wide         = (lgAQ >= lgNQ);
  assign pieceByteOff = {1'b0, ctl.piece} << lgNQ;
  assign pieceBytes   = {1'b0, pieceLastQ - ctl.piece} << lgNQ;
  assign pieceSh      = {pieceBytes, 3'b000};
  assign nBytes       = 3'd1 << lgNQ;
  assign aBytes       = 3'd1 << lgAQ;
  assign offIn        = {1'b0, baseQ[1:0] & 2'(nBytes - 3'd1)};
  assign laneBytes    = nBytes - aBytes - offIn;
  assign laneSh       = {laneBytes, 3'b000};
  assign nBits        = {nBytes, 3'b000};
  assign laneA        = laneMask(lgAQ);
  assign laneN        = laneMask(lgNQ);
  assign pieceData    = (wdQ >> pieceSh) & laneN;

  always_comb begin
    case (lgNQ)
      2'd0:    nativeAlign = baseQ;
      2'd1:    nativeAlign = {baseQ[ADDR_W-1:1], 1'b0};
      default: nativeAlign = {baseQ[ADDR_W-1:2], 2'b00};
    endcase
  end

  assign dnAddr  = wide ? (baseQ + {{(ADDR_W-3){1'b0}}, pieceByteOff}) : nativeAlign;
  assign dnSize  = lgNQ;
  assign dnWrite = ctl.issue && (ctl.rmwWr || (wrQ && !ctl.rmwRd));
  assign dnWdata = ctl.rmwWr ? accQ : pieceData;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ      <= '0;
      lgAQ       <= '0;
      lgNQ       <= '0;
      pieceLastQ <= '0;
      wrQ        <= 1'b0;
      isRmwQ     <= 1'b0;
      wdQ        <= '0;
      accQ       <= '0;
    end else if (ctl.load) begin
      baseQ  <= reqAlign;
      lgAQ   <= reqSize;
      lgNQ   <= lgNreq;
      wrQ    <= reqWrite;
      isRmwQ <= reqWrite && (reqSize < lgNreq);
      wdQ    <= reqWdata;
      accQ   <= '0;
      if (reqSize > lgNreq) pieceLastQ <= ((reqSize - lgNreq) == 2'd2) ? 2'd3 : 2'd1;
      else                  pieceLastQ <= 2'd0;
    end else if (ctl.issue) begin
      if (ctl.rmwRd) begin
        accQ <= (dnRdata & laneN & ~(laneA << laneSh)) | ((wdQ & laneA) << laneSh);
      end else if (!wrQ) begin
        if (wide) accQ <= (accQ << nBits) | (dnRdata & laneN);
        else      accQ <= (dnRdata >> laneSh) & laneA;
      end
    end
  end

  assign isRmw     = isRmwQ;
  assign pieceLast = pieceLastQ;
  assign rdata     = accQ;
endmodule

// File: rtl/regwidth_adapter.sv
module regwidth_adapter
  import rwa_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LIMIT = 'h200,
  parameter logic [2*MAX_SLOTS-1:0] SLOT_MAP = defaultMap()
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdata,
  output logic              dnValid,
  output logic              dnWrite,
  output logic [1:0]        dnSize,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [31:0]       dnWdata,
  input  logic [31:0]       dnRdata
);
  rwaCtl_t    ctl;
  logic       reqBad, isRmw;
  logic [1:0] pieceLast;

  rwa_ctrl ctrl_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqBad(reqBad), .isRmw(isRmw),
    .pieceLast(pieceLast), .ctl(ctl), .busy(busy), .done(done), .err(err)
  );

  rwa_datapath #(.ADDR_W(ADDR_W), .LIMIT(LIMIT), .SLOT_MAP(SLOT_MAP)) dp_i (
    .clk(clk), .rst(rst), .ctl(ctl), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBad(reqBad), .isRmw(isRmw),
    .pieceLast(pieceLast), .dnWrite(dnWrite), .dnAddr(dnAddr), .dnSize(dnSize),
    .dnWdata(dnWdata), .dnRdata(dnRdata), .rdata(rdata)
  );

  assign dnValid = ctl.issue;
endmodule

// File: rtl/rwa_checker.sv
module rwa_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              dnValid,
  input logic [1:0]        dnSize,
  input logic [ADDR_W-1:0] dnAddr
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && !err && !dnValid));

  // R2
  dn_size_chk: assert property (@(posedge clk) disable iff (rst)
    dnValid |-> (dnSize != 2'd3));

  // R2
  dn_align_chk: assert property (@(posedge clk) disable iff (rst)
    dnValid |-> ((dnSize == 2'd0) || (dnSize == 2'd1 && !dnAddr[0]) ||
                 (dnSize == 2'd2 && dnAddr[1:0] == 2'b00)));

  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(reqValid && !busy));

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!dnValid && !done));

  // R9
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(dnValid));

  // R9
  busy_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reqValid));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind regwidth_adapter rwa_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .reqValid(reqValid), .busy(busy), .done(done),
  .err(err), .dnValid(dnValid), .dnSize(dnSize), .dnAddr(dnAddr)
);

// File: tb/regwidth_adapter_tb_top.sv
module regwidth_adapter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [9:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        busy, done, err, dnValid, dnWrite;
  logic [31:0] rdata, dnWdata, dnRdata;
  logic [1:0]  dnSize;
  logic [9:0]  dnAddr;

  int checks = 0;
  int errors = 0;
  int accCount = 0;
  bit finished = 0;

  logic [7:0] periph [1024];
  logic [7:0] refMem [1024];

  typedef struct {
    bit          isErr;
    bit          isRead;
    logic [31:0] data;
    int          nAcc;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  regwidth_adapter dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy), .done(done), .err(err),
    .rdata(rdata), .dnValid(dnValid), .dnWrite(dnWrite), .dnSize(dnSize),
    .dnAddr(dnAddr), .dnWdata(dnWdata), .dnRdata(dnRdata)
  );

  // peripheral model: same-cycle reads, writes on the clock edge
  always_comb begin
    case (dnSize)
      2'd0:    dnRdata = {24'b0, periph[dnAddr]};
      2'd1:    dnRdata = {16'b0, periph[dnAddr], periph[dnAddr+10'd1]};
      default: dnRdata = {periph[dnAddr], periph[dnAddr+10'd1], periph[dnAddr+10'd2], periph[dnAddr+10'd3]};
    endcase
  end

  always @(posedge clk) begin
    if (dnValid && dnWrite) begin
      for (int k = 0; k < (1 << dnSize); k++)
        periph[dnAddr + 10'(k)] <= 8'(dnWdata >> (8 * ((1 << dnSize) - 1 - k)));
    end
  end

  // bench view of the default map (R2): 0 byte, 1 half, 2 word, 3 unused
  function automatic int nativeLg(input logic [9:0] a);
    return int'(a[7:6]);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (done || err) begin
        if (expQ.size() == 0) begin
          check(0, "R9", "unexpected completion", {30'b0, done, err}, 32'b0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(!(done && err), e.tag, "done and err together", {30'b0, done, err}, 32'b0);
          check(err == e.isErr, e.tag, "error flag", {31'b0, err}, {31'b0, e.isErr});
          if (e.isRead && !e.isErr)
            check(rdata == e.data, e.tag, "read data", rdata, e.data);
          check(accCount == e.nAcc, e.tag, "downstream access count", 32'(accCount), 32'(e.nAcc));
        end
        accCount = 0;
      end
      if (dnValid) begin
        accCount++;
        // R2: native width and alignment of every downstream access
        check(int'(dnSize) == nativeLg(dnAddr), "R2", "downstream size", {30'b0, dnSize}, 32'(nativeLg(dnAddr)));
        check((dnAddr & 10'((1 << dnSize) - 1)) == 10'd0, "R2", "downstream alignment", {22'b0, dnAddr}, 32'b0);
      end
    end
  end

  task automatic access(input bit w, input logic [1:0] sz, input logic [9:0] a,
                        input logic [31:0] wd, input string tag);
    exp_t e;
    logic [9:0] aa;
    int lgN, nb;
    bit bad;
    aa  = (sz == 2'd0) ? a : (sz == 2'd1) ? {a[9:1], 1'b0} : {a[9:2], 2'b00};
    lgN = nativeLg(a);
    bad = (sz == 2'd3) || (a > 10'h200) || (lgN == 3);
    nb  = 1 << sz;
    e.isErr  = bad;
    e.isRead = !w;
    e.tag    = tag;
    e.data   = '0;
    if (bad)                 e.nAcc = 0;
    else if (int'(sz) >= lgN) e.nAcc = 1 << (int'(sz) - lgN);
    else                      e.nAcc = w ? 2 : 1;
    if (!bad) begin
      for (int k = 0; k < nb; k++) begin
        if (w) refMem[aa + 10'(k)] = 8'(wd >> (8 * (nb - 1 - k)));
        else   e.data = (e.data << 8) | {24'b0, refMem[aa + 10'(k)]};
      end
    end
    expQ.push_back(e);
    reqValid = 1'b1; reqWrite = w; reqSize = sz; reqAddr = a; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (!(done || err)) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      periph[i] = 8'(i * 7 + 3);
      refMem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1: idle outputs during reset
    check(!busy && !done && !err && !dnValid, "R1", "reset state",
          {28'b0, busy, done, err, dnValid}, 32'b0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !err && !dnValid, "R1", "after reset",
          {28'b0, busy, done, err, dnValid}, 32'b0);

    access(0, 2'd2, 10'h010, 0, "R3");             // word read, byte regs
    access(0, 2'd1, 10'h022, 0, "R3");             // half read, byte regs
    access(0, 2'd2, 10'h048, 0, "R3");             // word read, half regs
    access(0, 2'd0, 10'h043, 0, "R4");             // odd byte of half reg
    access(0, 2'd0, 10'h042, 0, "R4");             // even byte of half reg
    access(0, 2'd1, 10'h086, 0, "R4");             // low half of word reg
    access(0, 2'd0, 10'h081, 0, "R4");             // byte of word reg
    access(0, 2'd2, 10'h080, 0, "R7");             // native word
    access(0, 2'd0, 10'h005, 0, "R7");             // native byte
    access(1, 2'd0, 10'h045, 32'hA5, "R6");        // byte into half reg
    access(0, 2'd1, 10'h044, 0, "R6");
    access(1, 2'd1, 10'h08A, 32'hBEEF, "R6");      // half into word reg
    access(0, 2'd2, 10'h088, 0, "R6");
    access(1, 2'd0, 10'h082, 32'h5A, "R6");        // byte into word reg
    access(0, 2'd2, 10'h080, 0, "R6");
    access(1, 2'd2, 10'h020, 32'h11223344, "R5");  // word into byte regs
    access(0, 2'd2, 10'h020, 0, "R5");
    access(0, 2'd0, 10'h021, 0, "R5");
    access(1, 2'd2, 10'h050, 32'hCAFEF00D, "R5");  // word into half regs
    access(0, 2'd1, 10'h052, 0, "R5");
    access(1, 2'd1, 10'h100, 32'h9876, "R5");      // half into byte regs
    access(0, 2'd0, 10'h100, 0, "R5");
    access(0, 2'd2, 10'h0C4, 0, "R8");             // unused slot read
    access(1, 2'd0, 10'h1C0, 32'h77, "R8");        // unused slot write
    access(0, 2'd0, 10'h201, 0, "R8");             // above limit
    access(0, 2'd3, 10'h010, 0, "R8");             // illegal size
    access(0, 2'd0, 10'h200, 0, "R2");             // limit itself, byte slot
    access(0, 2'd1, 10'h140, 0, "R2");             // second copy of half region
    access(0, 2'd2, 10'h013, 0, "R10");            // low bits dropped
    access(1, 2'd1, 10'h047, 32'h1234, "R10");
    access(0, 2'd1, 10'h046, 0, "R10");
    access(0, 2'd2, 10'h044, 0, "R9");             // overlap with previous done

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R9", "outstanding results", 32'(expQ.size()), 32'b0);
    finish_run();
  end
endmodule